// File: doc/BRIEF.md
# Parallel Flash Bank Query Responder

This block answers query-mode and identifier-mode reads for a bank of identical flash devices wired side by side on one data bus. A read gives a bus byte offset, the read size and three width codes: the bank width, the width each device is run at, and the widest width that device supports. The block turns the bus offset into a per-device table index. It looks up either a byte of a fixed query table or a 16-bit identifier code, then copies that per-device answer into every device slice of the bank word.

Reads wider than the bank are built from several bank-wide pieces placed side by side. Byte lanes above the requested size come back as zero. The table contents are fixed by parameters and derived inside the block. The result is registered and appears one clock after the read strobe.

All width inputs are log2 byte codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is illegal. Mode 0 reads the query table and mode 1 reads the identifiers.

Top module: `qry_replicator`

## Requirements
- R1: A read strobed on `rd_valid` gives `resp_valid` high on the next cycle, with the result on `resp_data`. Without a strobe, `resp_valid` is low on the next cycle and `resp_data` keeps its value. Reset clears both outputs to zero.
- R2: The table index is the offset shifted right by bank_lg + dmax_lg - dev_lg.
- R3: The query table holds 0x51, 0x52 and 0x59 at indices 0x10, 0x11 and 0x12, and 0x01 at index 0x13. Index 0x27 holds the SIZE_EXP parameter (default 0x17) and index 0x2C holds 0x01. Index 0x2A holds 0x08 when the bank is 1 byte wide and 0x0B otherwise. Every other index holds zero.
- R4: A query index greater than 0x52 returns zero, even when its low 8 bits name a non-zero entry.
- R5: When dev_lg < dmax_lg, a query is answered only for dev_lg = 0: the table byte is repeated across the native device width. Any other narrower setting returns zero.
- R6: The per-device answer, taken dev-width bytes wide, is copied into every dev-width slice of the bank-width word.
- R7: In identifier mode only the low 8 bits of the index count. Index 0 returns MFR_CODE (default 0x0089), index 1 returns DEV_CODE (default 0x227E), and any other index returns zero.
- R8: In a read wider than the bank, the piece at byte position i (a multiple of the bank width) uses offset + i × bank width and fills bytes i upward.
- R9: Byte lanes at or above 2^rd_size are zero.
- R10: Any of these returns zero in both modes: a width code of 3, dev_lg > dmax_lg, or dev_lg > bank_lg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Read strobe |
| rd_mode | input | 1 | 0 = query table, 1 = identifier |
| rd_offset | input | ADDR_W | Bus byte offset |
| rd_size | input | 2 | log2 of read size in bytes |
| bank_lg | input | 2 | log2 of bank width in bytes |
| dev_lg | input | 2 | log2 of device operating width in bytes |
| dmax_lg | input | 2 | log2 of device native width in bytes |
| resp_valid | output | 1 | Result valid, one cycle after the strobe |
| resp_data | output | 32 | Assembled response |

## Verification
The assertions check on every cycle the one-cycle handshake and the holding of data between reads. They also check the zeroing of lanes above a one-byte read, the zero result for a device wider than its bank, and the four equal bytes of a byte-mode device on a four-byte bank. Only the bench scenarios can show the table contents, the index shift, the limit on the table index, and the identifier aliasing on the low index byte. The same holds for the offsets each piece of a wide read uses and for the zero result of unsupported narrow modes, since these depend on values the properties do not model.

// File: rtl/qry_pkg.sv
// Shared definitions for the flash bank query responder.
// Assumes width codes are log2 byte counts and the bus is 4 bytes wide.
package qry_pkg;
    localparam int BUS_BYTES = 4;

    typedef enum logic {
        MODE_QUERY = 1'b0,
        MODE_IDENT = 1'b1
    } qry_mode_e;

    // Query table byte for an index already known to be within the table.
    function automatic logic [7:0] qry_tbl_byte(input logic [7:0] idx,
                                                input logic [1:0] bank_lg,
                                                input logic [7:0] size_exp);
        case (idx)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            8'h13:   return 8'h01;
            8'h27:   return size_exp;
            8'h2A:   return (bank_lg == 2'd0) ? 8'h08 : 8'h0B;
            8'h2C:   return 8'h01;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/qry_piece.sv
// One bank-wide piece of a response: it normalizes the offset to a
// per-device index, looks up the table byte or identifier code and
// copies the per-device answer across the bank.
// Assumes cfg_ok already screens out illegal width combinations.
module qry_piece
    import qry_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [7:0]  TBL_LIMIT = 8'h52,
    parameter logic [15:0] MFR_CODE  = 16'h0089,
    parameter logic [15:0] DEV_CODE  = 16'h227E,
    parameter logic [7:0]  SIZE_EXP  = 8'h17
) (
    input  logic              mode,
    input  logic [ADDR_W-1:0] off,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        dmax_lg,
    input  logic              cfg_ok,
    output logic [31:0]       piece_word
);
    logic [2:0]        shamt;
    logic [ADDR_W-1:0] idx;
    logic [7:0]        tbyte;
    logic [31:0]       dev_word;

    // Index normalization and table lookup.
    always_comb begin
        shamt = {1'b0, bank_lg} + {1'b0, dmax_lg} - {1'b0, dev_lg};
        idx   = off >> shamt;
        tbyte = (idx > ADDR_W'(TBL_LIMIT)) ? 8'h00
                                           : qry_tbl_byte(idx[7:0], bank_lg, SIZE_EXP);
    end

    // Per-device answer, including byte-mode repetition.
    always_comb begin
        dev_word = '0;
        if (mode == MODE_IDENT) begin
            if (idx[7:0] == 8'd0)      dev_word = {16'h0, MFR_CODE};
            else if (idx[7:0] == 8'd1) dev_word = {16'h0, DEV_CODE};
        end else if (dev_lg == dmax_lg) begin
            dev_word = {24'h0, tbyte};
        end else if (dev_lg == 2'd0) begin
            for (int j = 0; j < BUS_BYTES; j++)
                if (j < (1 << dmax_lg)) dev_word[8*j +: 8] = tbyte;
        end
    end

    // Copy the device slice into each device position of the bank.
    always_comb begin
        piece_word = '0;
        if (cfg_ok) begin
            for (int j = 0; j < BUS_BYTES; j++)
                if (j < (1 << bank_lg))
                    piece_word[8*j +: 8] = dev_word[8*(j & ((1 << dev_lg) - 1)) +: 8];
        end
    end
endmodule

// File: rtl/qry_merge.sv
// Places bank-wide pieces into the 32-bit bus word and zeroes lanes
// above the read size. Piece k is the one computed for byte position k.
module qry_merge
    import qry_pkg::*;
(
    input  logic [BUS_BYTES-1:0][31:0] pieces,
    input  logic [1:0]                 bank_lg,
    input  logic [1:0]                 size_lg,
    input  logic                       cfg_ok,
    output logic [31:0]                merged
);
    logic [1:0] jj;
    logic [1:0] lowm;
    logic [1:0] base;
    logic [1:0] sel;

    // Byte lane selection from the owning piece.
    always_comb begin
        merged = '0;
        jj   = '0;
        base = '0;
        sel  = '0;
        lowm = 2'((1 << bank_lg) - 1);
        for (int j = 0; j < BUS_BYTES; j++) begin
            jj   = 2'(j);
            base = jj & ~lowm;
            sel  = jj & lowm;
            if (cfg_ok && (j < (1 << size_lg)))
                merged[8*j +: 8] = pieces[base][8*sel +: 8];
        end
    end
endmodule

// File: rtl/qry_replicator.sv
// Query and identifier responder for a bank of parallel flash devices.
// Builds one piece per bus byte position, merges them and registers the
// result one cycle after the read strobe. Width codes of 3 are illegal.
module qry_replicator
    import qry_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [7:0]  TBL_LIMIT = 8'h52,
    parameter logic [15:0] MFR_CODE  = 16'h0089,
    parameter logic [15:0] DEV_CODE  = 16'h227E,
    parameter logic [7:0]  SIZE_EXP  = 8'h17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              rd_mode,
    input  logic [ADDR_W-1:0] rd_offset,
    input  logic [1:0]        rd_size,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        dmax_lg,
    output logic              resp_valid,
    output logic [31:0]       resp_data
);
    logic                          cfg_ok;
    logic [BUS_BYTES-1:0][31:0]    pieces;
    logic [31:0]                   merged;

    // Screen out illegal codes and impossible width orderings.
    always_comb begin
        cfg_ok = (bank_lg != 2'd3) && (dev_lg != 2'd3) && (dmax_lg != 2'd3) &&
                 (rd_size != 2'd3) && (dev_lg <= dmax_lg) && (dev_lg <= bank_lg);
    end

    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_piece
        logic [ADDR_W-1:0] off_k;
        // Offset for the piece at byte position k.
        always_comb off_k = rd_offset + (ADDR_W'(k) << bank_lg);

        qry_piece #(
            .ADDR_W(ADDR_W), .TBL_LIMIT(TBL_LIMIT), .MFR_CODE(MFR_CODE),
            .DEV_CODE(DEV_CODE), .SIZE_EXP(SIZE_EXP)
        ) u_piece (
            .mode(rd_mode), .off(off_k), .bank_lg(bank_lg), .dev_lg(dev_lg),
            .dmax_lg(dmax_lg), .cfg_ok(cfg_ok), .piece_word(pieces[k])
        );
    end

    qry_merge u_merge (
        .pieces(pieces), .bank_lg(bank_lg), .size_lg(rd_size),
        .cfg_ok(cfg_ok), .merged(merged)
    );

    // Response register: valid pulse and held data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= rd_valid;
            if (rd_valid) resp_data <= merged;
        end
    end
endmodule

// File: rtl/qry_replicator_chk.sv
// Property checker for the query responder, bound to every instance.
module qry_replicator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_valid,
    input logic [1:0]  rd_size,
    input logic [1:0]  bank_lg,
    input logic [1:0]  dev_lg,
    input logic [1:0]  dmax_lg,
    input logic        resp_valid,
    input logic [31:0] resp_data
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> resp_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !resp_valid);
    // R1
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(resp_data));
    // R9
    narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_size == 2'd0 |=> resp_data[31:8] == 24'h0);
    // R10
    bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && dev_lg > bank_lg |=> resp_data == 32'h0);
    // R6
    byte_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && dev_lg == 2'd0 && bank_lg == 2'd2 && rd_size == 2'd2 && dmax_lg != 2'd3
        |=> resp_data[15:8] == resp_data[7:0] && resp_data[23:16] == resp_data[7:0]
            && resp_data[31:24] == resp_data[7:0]);
endmodule

bind qry_replicator qry_replicator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_size(rd_size),
    .bank_lg(bank_lg), .dev_lg(dev_lg), .dmax_lg(dmax_lg),
    .resp_valid(resp_valid), .resp_data(resp_data)
);

// File: tb/qry_replicator_bench.sv
module qry_replicator_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MFR = 16'h0089;
    localparam logic [15:0] DEV = 16'h227E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic        rd_mode = 1'b0;
    logic [15:0] rd_offset = '0;
    logic [1:0]  rd_size = '0, bank_lg = '0, dev_lg = '0, dmax_lg = '0;
    logic        resp_valid;
    logic [31:0] resp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qry_replicator u_qry_replicator (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_mode(rd_mode),
        .rd_offset(rd_offset), .rd_size(rd_size), .bank_lg(bank_lg),
        .dev_lg(dev_lg), .dmax_lg(dmax_lg), .resp_valid(resp_valid),
        .resp_data(resp_data)
    );

    // Table contents as the requirements list them.
    function automatic logic [7:0] ref_tbl(int idx, int b);
        case (idx)
            'h10: return 8'h51;
            'h11: return 8'h52;
            'h12: return 8'h59;
            'h13: return 8'h01;
            'h27: return 8'h17;
            'h2A: return (b == 0) ? 8'h08 : 8'h0B;
            'h2C: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] ref_piece(bit mode, logic [15:0] off, int b, int d, int m);
        int idx;
        logic [31:0] dv, r;
        logic [7:0] tb;
        idx = int'(off) >> (b + m - d);
        dv = 0;
        r = 0;
        if (mode) begin
            if (idx % 256 == 0) dv = {16'h0, MFR};
            else if (idx % 256 == 1) dv = {16'h0, DEV};
        end else begin
            tb = (idx > 'h52) ? 8'h00 : ref_tbl(idx, b);
            if (d == m) dv = {24'h0, tb};
            else if (d == 0) for (int j = 0; j < (1 << m); j++) dv[8*j +: 8] = tb;
        end
        for (int j = 0; j < (1 << b); j++) r[8*j +: 8] = dv[8*(j % (1 << d)) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] ref_read(bit mode, logic [15:0] off, int sz, int b, int d, int m);
        logic [31:0] r, p;
        int k;
        r = 0;
        if (sz > 2 || b > 2 || d > 2 || m > 2 || d > m || d > b) return 0;
        for (int j = 0; j < (1 << sz); j++) begin
            k = j - (j % (1 << b));
            p = ref_piece(mode, 16'(int'(off) + k * (1 << b)), b, d, m);
            r[8*j +: 8] = p[8*(j - k) +: 8];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Drive one read at a falling edge and sample the result one cycle later.
    task automatic do_read(bit mode, logic [15:0] off, int sz, int b, int d, int m,
                           output logic [31:0] got);
        @(negedge clk);
        rd_valid = 1'b1; rd_mode = mode; rd_offset = off;
        rd_size = 2'(sz); bank_lg = 2'(b); dev_lg = 2'(d); dmax_lg = 2'(m);
        @(negedge clk);
        rd_valid = 1'b0;
        check("R1 valid", {31'h0, resp_valid}, 32'h1);
        got = resp_data;
    endtask

    task automatic lit(string tag, bit mode, logic [15:0] off, int sz, int b, int d, int m,
                       logic [31:0] exp);
        logic [31:0] got;
        do_read(mode, off, sz, b, d, m, got);
        check(tag, got, exp);
        check({tag, " model"}, ref_read(mode, off, sz, b, d, m), exp);
    endtask

    initial begin
        logic [31:0] got, held;
        int b, d, m;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'h0, resp_valid}, 32'h0);
        check("R1 reset data", resp_data, 32'h0);
        rst_n = 1'b1;

        lit("R3 Q byte", 0, 16'h0010, 0, 0, 0, 0, 32'h00000051);
        lit("R2 R5 byte mode x16 on 4-byte bank", 0, 16'h0088, 2, 2, 0, 1, 32'h52525252);
        lit("R5 unsupported narrow mode", 0, 16'h0088, 2, 2, 1, 2, 32'h00000000);
        lit("R4 index above limit", 0, 16'h0053, 0, 0, 0, 0, 32'h00000000);
        lit("R4 index aliasing low byte", 0, 16'h0110, 0, 0, 0, 0, 32'h00000000);
        lit("R7 manufacturer", 1, 16'h0000, 1, 1, 1, 1, 32'h00000089);
        lit("R7 device code", 1, 16'h0002, 1, 1, 1, 1, 32'h0000227E);
        lit("R7 low byte alias", 1, 16'h0200, 1, 1, 1, 1, 32'h00000089);
        lit("R7 other index", 1, 16'h0004, 1, 1, 1, 1, 32'h00000000);
        lit("R8 four pieces", 0, 16'h0010, 2, 0, 0, 0, 32'h01595251);
        lit("R8 two pieces", 0, 16'h0020, 2, 1, 1, 1, 32'h00590051);
        lit("R9 narrow read", 0, 16'h0040, 0, 2, 0, 0, 32'h00000051);
        lit("R3 buffer exp wide bank", 0, 16'h00A8, 2, 2, 0, 0, 32'h0B0B0B0B);
        lit("R3 buffer exp byte bank", 0, 16'h002A, 0, 0, 0, 0, 32'h00000008);
        lit("R3 size exp", 0, 16'h0027, 0, 0, 0, 0, 32'h00000017);
        lit("R6 ident per device", 1, 16'h0000, 2, 2, 1, 1, 32'h00890089);
        lit("R10 device wider than bank", 1, 16'h0000, 1, 0, 1, 1, 32'h00000000);
        lit("R10 illegal code", 0, 16'h0010, 0, 3, 0, 0, 32'h00000000);

        // R1: no strobe keeps data and drops valid.
        held = resp_data;
        repeat (3) @(negedge clk);
        check("R1 idle valid", {31'h0, resp_valid}, 32'h0);
        check("R1 idle hold", resp_data, held);

        for (int it = 0; it < 400; it++) begin
            logic [15:0] off;
            int sz;
            bit mode;
            if ($urandom % 8 == 0) begin
                b = $urandom % 4; d = $urandom % 4; m = $urandom % 4;
            end else begin
                b = $urandom % 3; d = $urandom % (b + 1); m = d + $urandom % (3 - d);
            end
            sz = $urandom % 3;
            mode = 1'($urandom % 2);
            off = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 'h400);
            do_read(mode, off, sz, b, d, m, got);
            check("R2 R3 R5 R6 R7 R8 R9 random", got, ref_read(mode, off, sz, b, d, m));
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule